// File: doc/BRIEF.md
# Serial Packet Transmit Framer

This block turns one parallel sensor sample into a serial radio packet. When a ready strobe arrives with a new 6-bit sample, the block captures the sample together with a 3-bit destination address. It then raises a 2-bit mode output to wake the transmitter for one clock. Next it shifts out a fixed synchronisation pattern, the address and the sample, one bit per clock. When the last bit has gone it puts the transmitter back to sleep. The transmit pins are separate from any receive path.

A busy flag covers the whole exchange. A strobe that arrives while a packet is in flight is held in a one-entry slot. It goes out after a single sleep clock that separates the two packets. While that slot is full, further strobes are discarded. Between packets the serial line rests low and the mode output reads sleep.

Top module: `tx_framer`

## Requirements
- R1: During and after reset, `tx_mode` is 00 (sleep), `tx_bit` is 0 and `busy` is 0.
- R2: A strobe sampled while idle makes `tx_mode` read 01 (active) and `busy` read 1 on the next clock. That first active clock is a wake cycle, and `tx_bit` is 0 in it.
- R3: After the wake cycle the line carries 17 bits, one per clock. The first 8 are the 8-bit sync pattern (default 10101011), most significant bit first. The 3 address bits follow, most significant bit first, and then the 6 sample bits, most significant bit first.
- R4: `tx_mode` is 01 for exactly 18 consecutive clocks per packet (wake cycle plus 17 bit clocks). It reads 00 on the clock after the last sample bit. No value other than 00 or 01 ever appears.
- R5: `busy` is 1 from the clock after an accepted strobe until `tx_mode` has returned to 00 with nothing queued. A lone packet keeps it high for 18 clocks.
- R6: A strobe that arrives while busy with the slot empty is kept. Its packet follows after exactly one clock with `tx_mode` 00 and `busy` still 1. Two queued packets therefore keep `busy` high for 37 clocks.
- R7: A strobe that arrives while the one-entry slot is already full produces no packet.
- R8: Whenever `tx_mode` is 00, `tx_bit` is 0.
- R9: The address and sample are taken when the strobe is accepted. Later changes on those inputs do not alter the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Ready strobe for a new sample |
| smp_addr | input | 3 | Destination address sent in the header |
| smp_data | input | 6 | Parallel sensor sample |
| tx_mode | output | 2 | Transmitter mode: 00 sleep, 01 active |
| tx_bit | output | 1 | Serial packet output |
| busy | output | 1 | Packet in progress or queued |

## Verification
The bound checker watches several rules on every clock: the mode encoding stays legal, the line is low whenever the mode is sleep, and a wake cycle carries a low bit. It also checks that an idle strobe wakes the transmitter at once, that every active window lasts exactly 18 clocks, and that a sleep clock with busy high is always followed by a new wake. The actual bit content of each packet can only be confirmed by the bench's scenarios. The same holds for capturing the sample at the strobe, the one-deep queue and the dropping of a third strobe. For these the bench compares each packet against the bits and the busy length it expects.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_BITS = 2'd2,
    ST_GAP  = 2'd3
  } fr_state_e;

  localparam logic [1:0] MODE_SLEEP  = 2'b00;
  localparam logic [1:0] MODE_ACTIVE = 2'b01;

endpackage

// File: rtl/tx_framer_seq.sv
module tx_framer_seq
  import tx_framer_pkg::*;
#(
  parameter int FRAME_W = 17
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      trig,
  input  logic      queued,
  output fr_state_e state_q,
  output logic      start,
  output logic      shift_en,
  output logic      take_slot,
  output logic [1:0] mode_q,
  output logic      busy_q
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  fr_state_e        nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    nxt       = state_q;
    cnt_d     = cnt_q;
    start     = 1'b0;
    shift_en  = 1'b0;
    take_slot = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          nxt   = ST_WAKE;
          start = 1'b1;
        end
      end
      ST_WAKE: begin
        nxt      = ST_BITS;
        shift_en = 1'b1;
        cnt_d    = '0;
      end
      ST_BITS: begin
        if (cnt_q == LAST) begin
          nxt = queued ? ST_GAP : ST_IDLE;
        end else begin
          shift_en = 1'b1;
          cnt_d    = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        nxt       = ST_WAKE;
        start     = 1'b1;
        take_slot = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= MODE_SLEEP;
      busy_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      cnt_q   <= cnt_d;
      mode_q  <= (nxt == ST_WAKE || nxt == ST_BITS) ? MODE_ACTIVE : MODE_SLEEP;
      busy_q  <= (nxt != ST_IDLE);
    end
  end

endmodule

// File: rtl/tx_framer_slot.sv
module tx_framer_slot
  import tx_framer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  fr_state_e         state_q,
  input  logic              take_slot,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              queued,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_data
);

  logic full_q;
  logic grab;

  assign grab   = trig && (state_q != ST_IDLE) && !full_q;
  assign queued = full_q || grab;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 1'b0;
      slot_addr <= '0;
      slot_data <= '0;
    end else if (take_slot) begin
      full_q <= 1'b0;
    end else if (grab) begin
      full_q    <= 1'b1;
      slot_addr <= in_addr;
      slot_data <= in_data;
    end
  end

endmodule

// File: rtl/tx_framer_shift.sv
module tx_framer_shift #(
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift_en,
  output logic               bit_q
);

  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      bit_q  <= 1'b0;
    end else if (load) begin
      sreg_q <= frame;
      bit_q  <= 1'b0;
    end else if (shift_en) begin
      bit_q  <= sreg_q[FRAME_W-1];
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
    end else begin
      bit_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import tx_framer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 6,
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'b1010_1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [DATA_W-1:0] smp_data,
  output logic [1:0]        tx_mode,
  output logic              tx_bit,
  output logic              busy
);

  localparam int FRAME_W = SYNC_W + ADDR_W + DATA_W;

  fr_state_e         state_q;
  logic              start, shift_en, take_slot, queued;
  logic [ADDR_W-1:0] slot_addr, ld_addr;
  logic [DATA_W-1:0] slot_data, ld_data;

  tx_framer_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk(clk), .rst(rst), .trig(smp_valid), .queued(queued),
    .state_q(state_q), .start(start), .shift_en(shift_en),
    .take_slot(take_slot), .mode_q(tx_mode), .busy_q(busy)
  );

  tx_framer_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst(rst), .trig(smp_valid), .state_q(state_q),
    .take_slot(take_slot), .in_addr(smp_addr), .in_data(smp_data),
    .queued(queued), .slot_addr(slot_addr), .slot_data(slot_data)
  );

  assign ld_addr = take_slot ? slot_addr : smp_addr;
  assign ld_data = take_slot ? slot_data : smp_data;

  tx_framer_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(start),
    .frame({SYNC_PAT, ld_addr, ld_data}),
    .shift_en(shift_en), .bit_q(tx_bit)
  );

endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk #(
  parameter int ACTIVE_LEN = 18
) (
  input logic       clk,
  input logic       rst,
  input logic       smp_valid,
  input logic [1:0] tx_mode,
  input logic       tx_bit,
  input logic       busy
);

  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= (tx_mode == 2'b01) ? run_q + 1'b1 : 8'd0;
  end

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (rst)
    tx_mode == 2'b00 || tx_mode == 2'b01);

  assert_window_len_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b00 && run_q != 0) |-> run_q == 8'(ACTIVE_LEN));

  assert_sleep_low_R8: assert property (@(posedge clk) disable iff (rst)
    tx_mode == 2'b00 |-> !tx_bit);

  assert_wake_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_mode[0]) |-> !tx_bit);

  assert_idle_wake_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && smp_valid) |=> (tx_mode == 2'b01 && busy));

  assert_active_busy_R5: assert property (@(posedge clk) disable iff (rst)
    tx_mode == 2'b01 |-> busy);

  assert_gap_then_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_mode == 2'b00) |=> tx_mode == 2'b01);

endmodule

bind tx_framer tx_framer_chk #(.ACTIVE_LEN(SYNC_W + ADDR_W + DATA_W + 1)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid),
  .tx_mode(tx_mode), .tx_bit(tx_bit), .busy(busy)
);

// File: tb/test_tx_framer.sv
module test_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SYNC = 8'b1010_1011;

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0;
  logic [2:0] smp_addr = '0;
  logic [5:0] smp_data = '0;
  logic [1:0] tx_mode;
  logic tx_bit, busy;

  int tests = 0, fails = 0, frames_done = 0, busy_run = 0, last_run = 0;
  logic [16:0] exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_framer i_tx_framer (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_addr(smp_addr),
    .smp_data(smp_data), .tx_mode(tx_mode), .tx_bit(tx_bit), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // busy run length, sampled away from the clock edge (R5, R6)
  always @(negedge clk) begin
    if (rst) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else begin
      if (busy_run != 0) last_run <= busy_run;
      busy_run <= 0;
    end
  end

  // monitor: pops expected packets and compares serial output
  initial begin
    logic [1:0]  prev_mode = 2'b00;
    logic [16:0] exp_f = '0, got = '0;
    int idx = 0;
    bit active = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!active && prev_mode == 2'b00 && tx_mode == 2'b01) begin
          check("R2 wake bit low", tx_bit, 0);
          if (exp_q.size() == 0) check("R7 unexpected packet", 1, 0);
          else exp_f = exp_q.pop_front();
          active = 1; idx = 0; got = '0;
        end else if (active) begin
          if (idx < 17) begin
            got = {got[15:0], tx_bit};
            if (tx_mode != 2'b01) check("R4 mode active during bits", tx_mode, 1);
            idx++;
          end else begin
            check("R3 packet bits", got, exp_f);
            check("R4 sleep after last bit", tx_mode, 0);
            active = 0; frames_done++;
          end
        end
        prev_mode = tx_mode;
      end
    end
  end

  task automatic trig(input logic [2:0] a, input logic [5:0] d, input bit push);
    @(negedge clk);
    smp_addr = a; smp_data = d; smp_valid = 1'b1;
    if (push) exp_q.push_back({SYNC, a, d});
    @(negedge clk);
    smp_valid = 1'b0; smp_addr = ~a; smp_data = ~d;  // R9: later input changes
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode in reset", tx_mode, 0);
    check("R1 bit in reset", tx_bit, 0);
    check("R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle line low", tx_bit, 0);

    trig(3'b010, 6'b000111, 1);
    check("R2 active after strobe", tx_mode, 1);
    check("R5 busy after strobe", busy, 1);
    wait_idle();
    check("R5 lone packet busy length", last_run, 18);
    check("R8 idle mode sleep", tx_mode, 0);
    check("R8 idle bit low", tx_bit, 0);

    trig(3'b111, 6'b111111, 1);   // R9 inputs flip right after
    wait_idle();
    trig(3'b000, 6'b000000, 1);
    wait_idle();
    trig(3'b101, 6'b100110, 1);
    wait_idle();

    // R6/R7: one queued, third strobe dropped
    trig(3'b001, 6'b101010, 1);
    repeat (3) @(negedge clk);
    trig(3'b110, 6'b010101, 1);
    trig(3'b011, 6'b110011, 0);
    wait_idle();
    check("R6 queued pair busy length", last_run, 37);
    check("R7 no extra packet", frames_done, 6);
    check("R7 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule